// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block is a bus master that turns single read or write requests from a core into phased transfers on a shared 16-line address/data bus. It places the address on the lines in two byte-wide steps, each marked by its own latch strobe, so that external latches can capture it. Then it uses the same lines for data. Requests can target memory or I/O space. An I/O transfer leaves out the second address step. A 2-bit byte-lane mask selects the low byte, the high byte or both.

A transfer runs through these phases: T1 (low address byte), then T2 (high address byte, memory only), then one or more TW data clocks, then T4. The number of extra TW clocks comes from a wait-count input, so a fast core can talk to slow memory. The controller never drives the shared lines directly. It produces the values to drive, an output-enable, and an input path, and the pad ring builds the tristate buffers from these. Read data comes back with a one-clock done pulse in T4. A new request is taken only while the controller is idle.

Top module: `mbus_ctrl`

## Requirements
- R1: ALE0 (`ale0_o`) is high only during T1, the first clock after a request is accepted. In T1, lines [7:1] carry address bits [7:1], line 0 carries the inverse of byte-enable bit 0 (0 = low byte used), and lines [15:8] are 0.
- R2: For memory transfers, T2 follows T1 as one clock. In T2, `ale1_o` is high and lines [7:0] carry address bits [15:8], with lines [15:8] at 0. `ale1_o` is low in every other clock.
- R3: When `pio_i` is high at acceptance, T2 is skipped: there is no `ale1_o` clock, and TW follows T1 directly. `pio_o` is high from T1 through T4 of that transfer and low when idle.
- R4: `bhe_no` is low from T1 through T4 exactly when byte-enable bit 1 (high byte) was set. It is high when idle.
- R5: `oe_no` is high during T1 and T2 and low during every TW clock and T4.
- R6: In a write, `we_no` is low for exactly wait+1 clocks (all TW clocks), and the lines are driven with the write data from the first TW clock through T4.
- R7: In a read, `io_oe_o` is low from the first TW clock through T4. `rdata_o` shows `io_i` during T4, holds the value sampled at the end of T4 afterwards, and ignores later changes on `io_i`.
- R8: A transfer lasts wait+4 clocks for memory and wait+3 clocks for I/O, from T1 through T4. `done_o` is a single-clock pulse in T4.
- R9: A request raised while a transfer is in progress is ignored. No second T1 follows, and the controller returns to idle after T4.
- R10: While reset is held and while idle, every strobe is inactive: ALE0/ALE1 low, `we_no`/`oe_no`/`bhe_no` high, `pio_o` and `done_o` low, and the lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request, taken only when idle |
| addr_i | input | 15 | Halfword address bits [15:1] |
| wdata_i | input | 16 | Write data |
| we_i | input | 1 | 1 = write, 0 = read |
| pio_i | input | 1 | 1 = I/O space, 0 = memory |
| be_i | input | 2 | Byte lanes: bit 0 low byte, bit 1 high byte |
| wait_i | input | 4 | Extra TW clocks |
| io_i | input | 16 | Value seen on the shared lines |
| io_o | output | 16 | Value to drive on the shared lines |
| io_oe_o | output | 1 | Drive enable for the shared lines |
| ale0_o | output | 1 | Low address byte latch strobe |
| ale1_o | output | 1 | High address byte latch strobe |
| we_no | output | 1 | Write strobe, active low |
| oe_no | output | 1 | Data phase enable, active low |
| bhe_no | output | 1 | High byte enable, active low |
| pio_o | output | 1 | I/O space indicator |
| rdata_o | output | 16 | Read data |
| done_o | output | 1 | Transfer complete pulse |

## Verification
The bench builds the block with its default parameters: a 16-line bus and a 4-bit wait count. With these defaults, both ends of the wait counter can be reached: zero extra TW clocks, and the maximum of 15, which gives a 19-clock memory write. The stimulus covers reads and writes in both memory and I/O space, with each byte-lane mask. It also covers a request raised in the middle of a transfer and a change on `io_i` after a read completes.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_TW   = 3'd3,
    PH_T4   = 3'd4
  } phase_e;
endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              pio_i,
  input  logic [WAIT_W-1:0] wait_i,
  output phase_e            phase_o,
  output logic              done_o
);
  phase_e            phase_q;
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_T1;
          cnt_q   <= wait_i;
        end
        PH_T1: phase_q <= pio_i ? PH_TW : PH_T2;
        PH_T2: phase_q <= PH_TW;
        PH_TW: begin
          if (cnt_q == '0) phase_q <= PH_T4;
          else cnt_q <= cnt_q - 1'b1;
        end
        PH_T4: phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign done_o  = (phase_q == PH_T4);

  AST_IO_SKIPS_T2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_T1 && pio_i) |=> (phase_q == PH_TW)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && !start_i) |=> (phase_q == PH_IDLE)); // R9
  AST_T4_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_T4) |=> (phase_q == PH_IDLE)); // R9
endmodule

// File: rtl/mbus_lanes.sv
module mbus_lanes
  import mbus_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  phase_e           phase_i,
  input  logic [BUS_W-1:1] addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic             we_i,
  input  logic             pio_i,
  input  logic [1:0]       be_i,
  input  logic [BUS_W-1:0] io_i,
  output logic [BUS_W-1:0] io_o,
  output logic             io_oe_o,
  output logic             ale0_o,
  output logic             ale1_o,
  output logic             we_no,
  output logic             oe_no,
  output logic             bhe_no,
  output logic             pio_o,
  output logic [BUS_W-1:0] rdata_o
);
  localparam int LANE_W = BUS_W / 2;

  logic             active;
  logic             data_ph;
  logic [BUS_W-1:0] rdata_q;

  assign active  = (phase_i != PH_IDLE);
  assign data_ph = (phase_i == PH_TW) || (phase_i == PH_T4);

  always_comb begin
    io_o    = '0;
    io_oe_o = 1'b0;
    unique case (phase_i)
      PH_T1: begin
        io_o    = {{LANE_W{1'b0}}, addr_i[LANE_W-1:1], ~be_i[0]};
        io_oe_o = 1'b1;
      end
      PH_T2: begin
        io_o    = {{LANE_W{1'b0}}, addr_i[BUS_W-1:LANE_W]};
        io_oe_o = 1'b1;
      end
      PH_TW, PH_T4: if (we_i) begin
        io_o    = wdata_i;
        io_oe_o = 1'b1;
      end
      default: ;
    endcase
  end

  assign ale0_o = (phase_i == PH_T1);
  assign ale1_o = (phase_i == PH_T2);
  assign we_no  = !(we_i && phase_i == PH_TW);
  assign oe_no  = !data_ph;
  assign bhe_no = !(active && be_i[1]);
  assign pio_o  = active && pio_i;

  // capture at the closing edge of T4
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           rdata_q <= '0;
    else if (phase_i == PH_T4 && !we_i)    rdata_q <= io_i;
  end

  assign rdata_o = (phase_i == PH_T4 && !we_i) ? io_i : rdata_q;

  AST_ALE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ale0_o && ale1_o)); // R1
  AST_OE_IN_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale0_o || ale1_o) |-> oe_no); // R5
  AST_READ_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !oe_no) |-> !io_oe_o); // R7
  AST_WE_WITH_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> (!oe_no && io_oe_o)); // R6
  AST_ALE1_NOT_IO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale1_o |-> !pio_o); // R3
endmodule

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
  import mbus_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [BUS_W-1:1]  addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              we_i,
  input  logic              pio_i,
  input  logic [1:0]        be_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic [BUS_W-1:0]  io_i,
  output logic [BUS_W-1:0]  io_o,
  output logic              io_oe_o,
  output logic              ale0_o,
  output logic              ale1_o,
  output logic              we_no,
  output logic              oe_no,
  output logic              bhe_no,
  output logic              pio_o,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              done_o
);
  phase_e           phase;
  logic             accept;
  logic [BUS_W-1:1] addr_q;
  logic [BUS_W-1:0] wdata_q;
  logic             we_q, pio_q;
  logic [1:0]       be_q;

  assign accept = req_i && (phase == PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      pio_q   <= 1'b0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      we_q    <= we_i;
      pio_q   <= pio_i;
      be_q    <= be_i;
    end
  end

  mbus_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (req_i),
    .pio_i   (pio_q),
    .wait_i  (wait_i),
    .phase_o (phase),
    .done_o  (done_o)
  );

  mbus_lanes #(.BUS_W(BUS_W)) u_lanes (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (phase),
    .addr_i  (addr_q),
    .wdata_i (wdata_q),
    .we_i    (we_q),
    .pio_i   (pio_q),
    .be_i    (be_q),
    .io_i    (io_i),
    .io_o    (io_o),
    .io_oe_o (io_oe_o),
    .ale0_o  (ale0_o),
    .ale1_o  (ale1_o),
    .we_no   (we_no),
    .oe_no   (oe_no),
    .bhe_no  (bhe_no),
    .pio_o   (pio_o),
    .rdata_o (rdata_o)
  );

  AST_ACCEPT_T1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> ale0_o); // R1
  AST_DONE_NOT_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!ale0_o && !ale1_o && !oe_no)); // R8
endmodule

// File: tb/sim_mbus_ctrl.sv
module sim_mbus_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [15:1] addr = '0;
  logic [15:0] wdata = '0;
  logic        we = 1'b0, pio = 1'b0;
  logic [1:0]  be = '0;
  logic [3:0]  wt = '0;
  logic [15:0] rd_val = '0;
  logic [15:0] io_i, io_o, rdata;
  logic        io_oe, ale0, ale1, we_n, oe_n, bhe_n, pio_o, done;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;
  assign io_i = io_oe ? io_o : rd_val;

  mbus_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .pio_i(pio), .be_i(be), .wait_i(wt), .io_i(io_i), .io_o(io_o),
    .io_oe_o(io_oe), .ale0_o(ale0), .ale1_o(ale1), .we_no(we_n), .oe_no(oe_n),
    .bhe_no(bhe_n), .pio_o(pio_o), .rdata_o(rdata), .done_o(done)
  );

  // {we, pio, be[1:0], wait[3:0], addr[15:0], wdata[15:0], rdval[15:0]}
  localparam int NV = 6;
  localparam logic [55:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'b11, 4'd0,  16'h1234, 16'hA5A5, 16'h0000},
    {1'b0, 1'b0, 2'b01, 4'd2,  16'hBEEF, 16'h0000, 16'h5A3C},
    {1'b1, 1'b1, 2'b10, 4'd1,  16'h00F1, 16'hC3C3, 16'h0000},
    {1'b0, 1'b1, 2'b11, 4'd0,  16'h8002, 16'h0000, 16'h0FF0},
    {1'b1, 1'b0, 2'b01, 4'd15, 16'hFFFE, 16'h1357, 16'h0000},
    {1'b0, 1'b0, 2'b10, 4'd5,  16'h0001, 16'h0000, 16'h9ABC}
  };

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(!ale0 && !ale1 && we_n && oe_n && bhe_n && !pio_o && !done && !io_oe,
        tag, "idle strobes", {ale0, ale1, we_n, oe_n, bhe_n, pio_o, done, io_oe},
        8'b0011_1000);
  endtask

  // runs one transfer; busy_poke raises req during the second clock
  task automatic xfer(input logic [55:0] v, input bit busy_poke);
    logic v_we, v_pio;
    logic [1:0] v_be;
    logic [3:0] v_wt;
    logic [15:0] v_ad, v_wd, v_rd;
    int cyc, n_ale0, n_ale1, n_wel, n_oel, bad_bhe, bad_pio, bad_wd, bad_rel, bad_oe_ad;
    logic [15:0] t1_lines, t2_lines, rd_at_done;
    {v_we, v_pio, v_be, v_wt, v_ad, v_wd, v_rd} = v;
    @(negedge clk);
    req = 1'b1; we = v_we; pio = v_pio; be = v_be; wt = v_wt;
    addr = v_ad[15:1]; wdata = v_wd; rd_val = v_rd;
    @(negedge clk);
    req = 1'b0;
    cyc = 0; n_ale0 = 0; n_ale1 = 0; n_wel = 0; n_oel = 0;
    bad_bhe = 0; bad_pio = 0; bad_wd = 0; bad_rel = 0; bad_oe_ad = 0;
    t1_lines = '1; t2_lines = '1; rd_at_done = '0;
    forever begin
      cyc++;
      if (ale0) begin n_ale0++; t1_lines = io_o; end
      if (ale1) begin n_ale1++; t2_lines = io_o; end
      if ((ale0 || ale1) && !oe_n) bad_oe_ad++;
      if (!we_n) n_wel++;
      if (!oe_n) begin
        n_oel++;
        if (v_we && !(io_oe && io_o == v_wd)) bad_wd++;
        if (!v_we && io_oe) bad_rel++;
      end
      if (bhe_n != !v_be[1]) bad_bhe++;
      if (pio_o != v_pio) bad_pio++;
      if (busy_poke && cyc == 2) begin
        req = 1'b1; addr = 15'h7777; we = 1'b1; pio = 1'b0;
      end else req = 1'b0;
      if (done || cyc > 40) begin rd_at_done = rdata; break; end
      @(negedge clk);
    end
    req = 1'b0;
    chk(n_ale0 == 1 && t1_lines == {8'h00, v_ad[7:1], ~v_be[0]}, "R1", "T1 lines",
        t1_lines, {8'h00, v_ad[7:1], ~v_be[0]});
    chk(n_ale1 == (v_pio ? 0 : 1), "R3", "ALE1 clocks", n_ale1, v_pio ? 0 : 1);
    if (!v_pio) chk(t2_lines == {8'h00, v_ad[15:8]}, "R2", "T2 lines", t2_lines,
                    {8'h00, v_ad[15:8]});
    chk(bad_pio == 0, "R3", "pio_o level", bad_pio, 0);
    chk(bad_bhe == 0, "R4", "bhe_no level", bad_bhe, 0);
    chk(n_oel == v_wt + 2 && bad_oe_ad == 0, "R5", "oe_no low clocks", n_oel, v_wt + 2);
    chk(n_wel == (v_we ? v_wt + 1 : 0), "R6", "we_no low clocks", n_wel,
        v_we ? v_wt + 1 : 0);
    if (v_we) chk(bad_wd == 0, "R6", "write data on lines", bad_wd, 0);
    else begin
      chk(bad_rel == 0, "R7", "lines released", bad_rel, 0);
      chk(rd_at_done == v_rd, "R7", "rdata with done", rd_at_done, v_rd);
    end
    chk(cyc == v_wt + (v_pio ? 3 : 4), "R8", "transfer clocks", cyc,
        v_wt + (v_pio ? 3 : 4));
    @(negedge clk);
    chk(!done, "R8", "done single pulse", done, 0);
    if (!v_we) begin
      rd_val = ~v_rd;
      #1;
      chk(rdata == v_rd, "R7", "rdata holds", rdata, v_rd);
    end
    if (busy_poke) begin
      chk(!ale0, "R9", "no T1 after busy req", ale0, 0);
      chk_idle("R9");
    end
  endtask

  initial begin : watchdog
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    req = 1'b1;
    repeat (3) @(negedge clk);
    chk_idle("R10");
    req = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R10");
    for (int i = 0; i < NV; i++) xfer(VEC[i], 1'b0);
    // mid-transfer request ignored
    xfer({1'b0, 1'b0, 2'b11, 4'd3, 16'h4242, 16'h0000, 16'h6DB6}, 1'b1);
    repeat (3) @(negedge clk);
    chk_idle("R10");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule